// File: doc/BRIEF.md
# Front-end event error checker

This block sits behind the deserializer of a calorimeter front-end link. It watches the stream of 16-bit event words and checks each event for errors. The stream is split into eight channel groups, each with eight channels. An event starts when the all-ones header word arrives while the block is idle. From then on the block follows the fixed layout of the event word by word.

While the event runs, the block checks odd parity on every payload word. It compares each group's control words and per-sample capacitor address words against those of group 0. It also tracks each channel's gain bits across all time samples. The findings collect in an 8-bit error word. That word appears with a one-cycle strobe right after the event's trailer word. The next event can follow at once, with no gap.

Top module: `fec_err_checker`

## Requirements
- R1: During reset, and until the first event completes, `stat_valid` is 0 and `stat_word` is 0.
- R2: While idle, only the word 0xFFFF with `in_valid` high starts an event, and any other idle word has no effect. A cycle with `in_valid` low never advances the layout and never changes the error state.
- R3: After the header, each group carries three control words (1, 2, 3) and then NSAMP sample blocks. Each sample block holds one address word followed by eight channel words. Groups 1..7 each begin with a header slot, and a single trailer word of any value follows group 7. `stat_valid` is high for exactly the one cycle after the trailer is accepted, and `stat_word` holds the event's error word.
- R4: Control, address and channel words must have odd parity over all 16 bits. Header slots and the trailer are not checked. `stat_word[7:6]` counts parity failures and saturates at 3.
- R5: `stat_word[0]` is set when the header slot of any of groups 1..7 holds a word other than 0xFFFF.
- R6: `stat_word[1]`, `[2]` and `[5]` are set when bits [14:0] of control word 1, 2 or 3 in any group 1..7 differ from the same control word in group 0.
- R7: `stat_word[3]` is set when bits [14:0] of an address word in groups 1..7 differ from group 0's address word for the same sample.
- R8: `stat_word[4]` is set when a channel word's gain field, bits [13:12], differs from the gain that channel carried in sample 0 of the same event. This holds even when sample 0 itself carried the odd value.
- R9: The error state clears at every accepted header. An event that directly follows a bad one reports only its own errors.
- R10: Once an error bit is raised it stays set until the end of the event. A single word can raise a parity count and a mismatch or gain flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_word` carries a stream word this cycle |
| in_word | input | 16 | Deserialized front-end word |
| stat_valid | output | 1 | One-cycle strobe after the trailer |
| stat_word | output | 8 | Error word of the finished event |

## Verification
Two things can happen in the same cycle. First, one word can fail parity and also break a gain or control comparison. The bench provokes this by flipping only bit 12 of a channel word, or only bit 0 of a control word. Both the count and the flag must then appear in the reported word. Second, the status strobe of one event falls in the same cycle as the header of the next. Events are therefore sent back to back, an erroneous one directly before a clean one. The bench judges each status against values it works out from the flipped positions, compared on every clock.

// File: rtl/fec_pkg.sv
package fec_pkg;

  typedef enum logic [1:0] {
    SL_HDR  = 2'd0,
    SL_CTL  = 2'd1,
    SL_RADD = 2'd2,
    SL_CHAN = 2'd3
  } slot_e;

  localparam int unsigned NUM_CTL = 3;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/fec_seq.sv
module fec_seq
  import fec_pkg::*;
#(
  parameter int unsigned W          = 16,
  parameter logic [W-1:0] HDR       = 16'hFFFF,
  parameter int unsigned NGRP       = 8,
  parameter int unsigned CH_PER_GRP = 8,
  parameter int unsigned NSAMP      = 5,
  localparam int unsigned GW = $clog2(NGRP + 1),
  localparam int unsigned CW = idx_w(CH_PER_GRP),
  localparam int unsigned SW = idx_w(NSAMP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_word,
  output logic          busy,
  output logic          start,
  output logic          is_hdr,
  output logic          is_ctl,
  output logic [1:0]    ctl_sel,
  output logic          is_radd,
  output logic          is_chan,
  output logic          is_trl,
  output logic [GW-1:0] grp,
  output logic [CW-1:0] chn,
  output logic [SW-1:0] smp
);

  localparam logic [GW-1:0] GRP_END  = GW'(NGRP);
  localparam logic [CW-1:0] CHN_LAST = CW'(CH_PER_GRP - 1);
  localparam logic [SW-1:0] SMP_LAST = SW'(NSAMP - 1);
  localparam logic [1:0]    CTL_LAST = 2'(NUM_CTL - 1);

  logic          busy_q;
  slot_e         slot_q;
  logic [GW-1:0] grp_q;
  logic [1:0]    ctl_q;
  logic [CW-1:0] chn_q;
  logic [SW-1:0] smp_q;
  logic          take;
  logic          at_trl;

  assign take   = in_valid && busy_q;
  assign at_trl = (grp_q == GRP_END);

  always_comb begin
    start   = in_valid && !busy_q && (in_word == HDR);
    is_trl  = take && at_trl;
    is_hdr  = take && !at_trl && (slot_q == SL_HDR);
    is_ctl  = take && !at_trl && (slot_q == SL_CTL);
    is_radd = take && !at_trl && (slot_q == SL_RADD);
    is_chan = take && !at_trl && (slot_q == SL_CHAN);
  end

  assign busy    = busy_q;
  assign grp     = grp_q;
  assign chn     = chn_q;
  assign smp     = smp_q;
  assign ctl_sel = ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      slot_q <= SL_HDR;
      grp_q  <= '0;
      ctl_q  <= '0;
      chn_q  <= '0;
      smp_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      slot_q <= SL_CTL;
      grp_q  <= '0;
      ctl_q  <= '0;
      chn_q  <= '0;
      smp_q  <= '0;
    end else if (take) begin
      if (at_trl) begin
        busy_q <= 1'b0;
      end else begin
        case (slot_q)
          SL_HDR: begin
            slot_q <= SL_CTL;
            ctl_q  <= '0;
          end
          SL_CTL: begin
            if (ctl_q == CTL_LAST) begin
              slot_q <= SL_RADD;
              smp_q  <= '0;
            end else begin
              ctl_q <= ctl_q + 2'd1;
            end
          end
          SL_RADD: begin
            slot_q <= SL_CHAN;
            chn_q  <= '0;
          end
          default: begin
            if (chn_q == CHN_LAST) begin
              chn_q <= '0;
              if (smp_q == SMP_LAST) begin
                smp_q  <= '0;
                slot_q <= SL_HDR;
                grp_q  <= grp_q + 1'b1;
              end else begin
                smp_q  <= smp_q + 1'b1;
                slot_q <= SL_RADD;
              end
            end else begin
              chn_q <= chn_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/fec_parity.sv
module fec_parity #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         chk,
  input  logic [W-1:0] word,
  output logic [1:0]   cnt
);

  logic bad;

  assign bad = chk && !(^word);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= 2'd0;
    end else if (bad && (cnt != 2'd3)) begin
      cnt <= cnt + 2'd1;
    end
  end

endmodule

// File: rtl/fec_xgrp.sv
module fec_xgrp
  import fec_pkg::*;
#(
  parameter int unsigned DW    = 15,
  parameter int unsigned NSAMP = 5,
  parameter int unsigned GW    = 4,
  localparam int unsigned SW = idx_w(NSAMP)
) (
  input  logic               clk,
  input  logic               is_ctl,
  input  logic [1:0]         ctl_sel,
  input  logic               is_radd,
  input  logic [GW-1:0]      grp,
  input  logic [SW-1:0]      smp,
  input  logic [DW-1:0]      data,
  output logic [NUM_CTL-1:0] mis_ctl,
  output logic               mis_radd
);

  logic          ref_grp;
  logic [DW-1:0] radd_ref [NSAMP];

  assign ref_grp = (grp == '0);

  for (genvar i = 0; i < NUM_CTL; i++) begin : g_ctl
    logic [DW-1:0] ctl_ref;
    logic          hit;

    assign hit = is_ctl && (ctl_sel == 2'(i));

    always_ff @(posedge clk) begin
      if (hit && ref_grp) begin
        ctl_ref <= data;
      end
    end

    assign mis_ctl[i] = hit && !ref_grp && (data != ctl_ref);
  end

  always_ff @(posedge clk) begin
    if (is_radd && ref_grp) begin
      radd_ref[smp] <= data;
    end
  end

  assign mis_radd = is_radd && !ref_grp && (data != radd_ref[smp]);

endmodule

// File: rtl/fec_gain.sv
module fec_gain
  import fec_pkg::*;
#(
  parameter int unsigned NGRP       = 8,
  parameter int unsigned CH_PER_GRP = 8,
  parameter int unsigned NSAMP      = 5,
  parameter int unsigned GAIN_W     = 2,
  parameter int unsigned GW         = 4,
  localparam int unsigned NCH = NGRP * CH_PER_GRP,
  localparam int unsigned CHW = idx_w(NCH),
  localparam int unsigned CW  = idx_w(CH_PER_GRP),
  localparam int unsigned SW  = idx_w(NSAMP)
) (
  input  logic              clk,
  input  logic              is_chan,
  input  logic [GW-1:0]     grp,
  input  logic [CW-1:0]     chn,
  input  logic [SW-1:0]     smp,
  input  logic [GAIN_W-1:0] gain,
  output logic              mis
);

  logic [GAIN_W-1:0] gref [NCH];
  logic [CHW-1:0]    idx;
  logic              first;

  assign idx   = CHW'(int'(grp) * CH_PER_GRP + int'(chn));
  assign first = (smp == '0);

  always_ff @(posedge clk) begin
    if (is_chan && first) begin
      gref[idx] <= gain;
    end
  end

  assign mis = is_chan && !first && (gain != gref[idx]);

endmodule

// File: rtl/fec_err_checker.sv
module fec_err_checker
  import fec_pkg::*;
#(
  parameter int unsigned W          = 16,
  parameter logic [W-1:0] HDR       = 16'hFFFF,
  parameter int unsigned NGRP       = 8,
  parameter int unsigned CH_PER_GRP = 8,
  parameter int unsigned NSAMP      = 5,
  parameter int unsigned GAIN_LSB   = 12,
  parameter int unsigned GAIN_W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_word,
  output logic         stat_valid,
  output logic [7:0]   stat_word
);

  localparam int unsigned GW = $clog2(NGRP + 1);
  localparam int unsigned CW = idx_w(CH_PER_GRP);
  localparam int unsigned SW = idx_w(NSAMP);
  localparam int unsigned DW = W - 1;

  logic               busy;
  logic               start;
  logic               is_hdr;
  logic               is_ctl;
  logic [1:0]         ctl_sel;
  logic               is_radd;
  logic               is_chan;
  logic               is_trl;
  logic [GW-1:0]      grp;
  logic [CW-1:0]      chn;
  logic [SW-1:0]      smp;
  logic [1:0]         pcnt;
  logic [NUM_CTL-1:0] mis_ctl;
  logic               mis_radd;
  logic               mis_gain;
  logic [5:0]         flags_q;
  logic [7:0]         acc;

  fec_seq #(
    .W(W), .HDR(HDR), .NGRP(NGRP), .CH_PER_GRP(CH_PER_GRP), .NSAMP(NSAMP)
  ) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .busy(busy), .start(start), .is_hdr(is_hdr), .is_ctl(is_ctl),
    .ctl_sel(ctl_sel), .is_radd(is_radd), .is_chan(is_chan),
    .is_trl(is_trl), .grp(grp), .chn(chn), .smp(smp)
  );

  fec_parity #(.W(W)) u_par (
    .clk(clk), .rst(rst), .clr(start),
    .chk(is_ctl || is_radd || is_chan),
    .word(in_word), .cnt(pcnt)
  );

  fec_xgrp #(.DW(DW), .NSAMP(NSAMP), .GW(GW)) u_xgrp (
    .clk(clk), .is_ctl(is_ctl), .ctl_sel(ctl_sel), .is_radd(is_radd),
    .grp(grp), .smp(smp), .data(in_word[DW-1:0]),
    .mis_ctl(mis_ctl), .mis_radd(mis_radd)
  );

  fec_gain #(
    .NGRP(NGRP), .CH_PER_GRP(CH_PER_GRP), .NSAMP(NSAMP),
    .GAIN_W(GAIN_W), .GW(GW)
  ) u_gain (
    .clk(clk), .is_chan(is_chan), .grp(grp), .chn(chn), .smp(smp),
    .gain(in_word[GAIN_LSB +: GAIN_W]), .mis(mis_gain)
  );

  always_ff @(posedge clk) begin
    if (rst || start) begin
      flags_q <= '0;
    end else begin
      if (is_hdr && (in_word != HDR)) flags_q[0] <= 1'b1;
      if (mis_ctl[0])                 flags_q[1] <= 1'b1;
      if (mis_ctl[1])                 flags_q[2] <= 1'b1;
      if (mis_radd)                   flags_q[3] <= 1'b1;
      if (mis_gain)                   flags_q[4] <= 1'b1;
      if (mis_ctl[2])                 flags_q[5] <= 1'b1;
    end
  end

  assign acc = {pcnt, flags_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_valid <= 1'b0;
      stat_word  <= '0;
    end else begin
      stat_valid <= is_trl;
      if (is_trl) stat_word <= acc;
    end
  end

endmodule

// File: rtl/fec_err_checker_chk.sv
module fec_err_checker_chk #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] HDR = 16'hFFFF
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_word,
  input logic         stat_valid,
  input logic [7:0]   stat_word,
  input logic         busy,
  input logic [7:0]   acc
);

  AST_STRB_PULSE: assert property (@(posedge clk) disable iff (rst)
    stat_valid |=> !stat_valid); // R3

  AST_STAT_IS_ACC: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> (stat_word == acc)); // R3

  AST_HOLD_NOVALID: assert property (@(posedge clk) disable iff (rst)
    (busy && !in_valid) |=> $stable(acc)); // R2

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!busy && in_valid && in_word == HDR) |=> (busy && acc == 8'd0)); // R9

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    busy |=> ((acc[5:0] & $past(acc[5:0])) == $past(acc[5:0]))); // R10

  AST_PCNT_MONO: assert property (@(posedge clk) disable iff (rst)
    busy |=> (acc[7:6] >= $past(acc[7:6]))); // R4

  AST_PCNT_STEP: assert property (@(posedge clk) disable iff (rst)
    busy |=> ({1'b0, acc[7:6]} <= {1'b0, $past(acc[7:6])} + 3'd1)); // R4

endmodule

bind fec_err_checker fec_err_checker_chk #(.W(W), .HDR(HDR)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
  .stat_valid(stat_valid), .stat_word(stat_word),
  .busy(busy), .acc(acc)
);

// File: tb/tb_fec_err_checker.sv
module tb_fec_err_checker;

  localparam int NG  = 8;
  localparam int CP  = 8;
  localparam int NS  = 5;
  localparam int GL  = 4 + NS * (CP + 1);
  localparam int EVL = NG * GL + 1;
  localparam logic [15:0] HDRW = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = 16'h0;
  logic        stat_valid;
  logic [7:0]  stat_word;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  string cur_req = "R1";
  logic        pend   = 1'b0;
  logic [7:0]  pend_w = 8'h00;
  logic [15:0] ev [$];

  always #2 clk = ~clk;

  fec_err_checker dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .stat_valid(stat_valid), .stat_word(stat_word)
  );

  function automatic logic [15:0] mkw(input logic [14:0] v);
    return {~(^v), v};
  endfunction

  function automatic int ix_ctl(input int g, input int c);
    return g * GL + 1 + c;
  endfunction
  function automatic int ix_radd(input int g, input int s);
    return g * GL + 4 + s * (CP + 1);
  endfunction
  function automatic int ix_ch(input int g, input int s, input int p);
    return g * GL + 4 + s * (CP + 1) + 1 + p;
  endfunction

  task automatic build_clean();
    ev.delete();
    for (int g = 0; g < NG; g++) begin
      ev.push_back(HDRW);
      for (int c = 0; c < 3; c++) ev.push_back(mkw(15'(16'h0100 + c)));
      for (int s = 0; s < NS; s++) begin
        ev.push_back(mkw(15'(16'h0200 + s)));
        for (int p = 0; p < CP; p++) begin
          logic [1:0] gn;
          gn = 2'((g * CP + p) % 3);
          ev.push_back(mkw({1'b0, gn, 12'(g * 16 + p * 3 + s)}));
        end
      end
    end
    ev.push_back(16'h0000);
  endtask

  function automatic void flip(input int i, input int b);
    ev[i] = ev[i] ^ (16'h1 << b);
  endfunction

  // behavioural model working directly on word positions
  function automatic logic [7:0] model();
    logic [7:0] r;
    int pc;
    r = 8'h00;
    pc = 0;
    for (int i = 1; i < EVL - 1; i++) begin
      int g, o;
      g = i / GL;
      o = i % GL;
      if (o == 0) begin
        if (ev[i] != HDRW) r[0] = 1'b1;
      end else begin
        if (!(^ev[i])) pc++;
        if (o <= 3) begin
          if (g > 0 && ev[i][14:0] != ev[o][14:0]) begin
            if (o == 1) r[1] = 1'b1;
            if (o == 2) r[2] = 1'b1;
            if (o == 3) r[5] = 1'b1;
          end
        end else begin
          int k, p;
          k = o - 4;
          p = k % (CP + 1);
          if (p == 0) begin
            if (g > 0 && ev[i][14:0] != ev[o][14:0]) r[3] = 1'b1;
          end else begin
            if (ev[i][13:12] != ev[g * GL + 4 + p][13:12]) r[4] = 1'b1;
          end
        end
      end
    end
    r[7:6] = (pc > 3) ? 2'd3 : 2'(pc);
    return r;
  endfunction

  task automatic step(input logic v, input logic [15:0] w, input logic trl,
                      input logic [7:0] e);
    @(negedge clk);
    n_tests++;
    if (stat_valid !== pend || (pend && stat_word !== pend_w)) begin
      n_fail++;
      $display("FAIL %s: stat_valid=%0b stat_word=%02h expected valid=%0b word=%02h",
               cur_req, stat_valid, stat_word, pend, pend_w);
    end
    in_valid = v;
    in_word  = w;
    pend     = trl;
    pend_w   = e;
  endtask

  task automatic send_event(input logic [7:0] e, input int gap);
    for (int i = 0; i < EVL; i++) begin
      if (gap > 0 && i % gap == 3) step(1'b0, 16'hFFFF, 1'b0, 8'h00);
      step(1'b1, ev[i], (i == EVL - 1), e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_tests++;
    if (stat_valid !== 1'b0 || stat_word !== 8'h00) begin
      n_fail++;
      $display("FAIL R1: valid=%0b word=%02h expected 0/00", stat_valid, stat_word);
    end
    rst = 1'b0;

    // R1 / R2: idle words other than the header change nothing
    cur_req = "R2";
    step(1'b1, 16'h1234, 1'b0, 8'h00);
    step(1'b1, 16'hFFFE, 1'b0, 8'h00);
    step(1'b0, 16'hFFFF, 1'b0, 8'h00);
    step(1'b1, 16'h0000, 1'b0, 8'h00);
    n_tests++;
    if (stat_word !== 8'h00) begin
      n_fail++;
      $display("FAIL R1: word=%02h expected 00 before first event", stat_word);
    end

    cur_req = "R3";  build_clean(); send_event(8'h00, 0);
    cur_req = "R2";  build_clean(); send_event(8'h00, 7);
    cur_req = "R3";  build_clean(); ev[EVL-1] = 16'h5555; send_event(8'h00, 0);

    cur_req = "R4";  build_clean(); flip(ix_ch(3, 2, 4), 15); send_event(8'h40, 0);
    cur_req = "R4";  build_clean(); flip(ix_ctl(0, 1), 15); flip(ix_radd(6, 0), 15);
    send_event(8'h80, 0);
    cur_req = "R4";  build_clean();
    for (int k = 0; k < 5; k++) flip(ix_ch(k, k, k), 15);
    send_event(8'hC0, 0);

    cur_req = "R5";  build_clean(); ev[5 * GL] = mkw(15'h0123); send_event(8'h01, 0);
    cur_req = "R5";  build_clean(); ev[7 * GL] = 16'h0000; send_event(8'h01, 0);

    cur_req = "R6";  build_clean(); flip(ix_ctl(2, 0), 0); flip(ix_ctl(2, 0), 15);
    send_event(8'h02, 0);
    cur_req = "R6";  build_clean(); flip(ix_ctl(7, 1), 3); flip(ix_ctl(7, 1), 15);
    send_event(8'h04, 0);
    cur_req = "R6";  build_clean(); flip(ix_ctl(1, 2), 9); flip(ix_ctl(1, 2), 15);
    send_event(8'h20, 0);
    cur_req = "R6";  build_clean(); flip(ix_ctl(0, 0), 1); flip(ix_ctl(0, 0), 15);
    send_event(8'h02, 0);

    cur_req = "R7";  build_clean(); flip(ix_radd(4, 3), 2); flip(ix_radd(4, 3), 15);
    send_event(8'h08, 0);

    cur_req = "R8";  build_clean(); flip(ix_ch(1, 4, 5), 12); flip(ix_ch(1, 4, 5), 15);
    send_event(8'h10, 0);
    cur_req = "R8";  build_clean(); flip(ix_ch(6, 0, 2), 13); flip(ix_ch(6, 0, 2), 15);
    send_event(8'h10, 0);

    cur_req = "R10"; build_clean(); flip(ix_ch(6, 1, 0), 12); send_event(8'h50, 0);
    cur_req = "R10"; build_clean(); flip(ix_ctl(3, 0), 0); send_event(8'h42, 0);
    cur_req = "R10"; build_clean();
    ev[2 * GL] = mkw(15'h0001);
    flip(ix_ctl(1, 0), 0); flip(ix_ctl(1, 1), 0); flip(ix_ctl(1, 2), 0);
    flip(ix_radd(3, 1), 0); flip(ix_ch(4, 2, 1), 12);
    send_event(8'hFF, 0);

    cur_req = "R9";  build_clean(); send_event(8'h00, 0);

    cur_req = "R10";
    for (int n = 0; n < 20; n++) begin
      int nf;
      build_clean();
      nf = 1 + int'($urandom_range(0, 3));
      for (int f = 0; f < nf; f++) begin
        int pos, sel;
        pos = 1 + int'($urandom_range(0, EVL - 3));
        sel = int'($urandom_range(0, 3));
        flip(pos, (sel == 0) ? 15 : (sel == 1) ? 13 : (sel == 2) ? 12 : 3);
      end
      send_event(model(), (n % 4 == 0) ? 11 : 0);
    end

    step(1'b0, 16'h0000, 1'b0, 8'h00);
    step(1'b0, 16'h0000, 1'b0, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule